// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when the core of a small microcontroller is held in reset, and for how long. It takes four sources of reset: an active-low external pin (power-on cold reset or warm reset), a watchdog overflow pulse, a software reset request, and a bidirectional option in which internally caused resets are pushed back out onto the pin through an open-drain pull. Reset entry from the pin takes effect at once without any clock edge. The release of the pin is seen only after it has passed a synchronizer.

Every reset runs through the same phases. First comes a transition phase. In it, hold requests are cancelled, internal accesses drain, and any outstanding external bus cycle is either aborted or allowed to finish, depending on the cause. Then comes a fixed internal sequence of 512 clock cycles. If the pin is still low when the sequence ends, reset is stretched until the pin releases. A two-bit cause register tells the restarted software why reset happened. A bidirectional-enable bit, set by software, is cleared whenever a sequence ends.

Top module: `rstseq_top`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst` and `io_hiz` are 1 and `rst_out_n` is 0 combinationally. This holds before any clock edge and in every state.
- R2: A rising `ext_rst_n` is seen by the sequencer only after two rising clock edges. After a pin reset, `core_rst` is 1 for the 2 synchronizer cycles, 1 transition cycle and 512 sequence cycles (515 samples) before `rst_out_n` returns to 1.
- R3: `rst_cause` records the winning source and keeps it in normal operation: 0 = pin with `prog_volt_hi` low (cold), 1 = pin with `prog_volt_hi` high (warm), 2 = watchdog, 3 = software.
- R4: During the transition phase `hold_cancel` is 1. The phase lasts while `int_busy` is 1. For software and watchdog causes `core_rst` stays 0 during the phase.
- R5: The internal sequence asserts `core_rst` for exactly 512 consecutive cycles, starting the cycle after the transition phase ends.
- R6: A low pin during the sequence does not restart the sequence. If the pin is still low when the count ends, reset is held until the synchronized pin is high, and `rst_out_n` returns to 1 on the third rising edge after release. The cause is kept.
- R7: In normal operation, a `soft_rst_req` pulse starts the transition phase on the next edge.
- R8: For a watchdog cause, a busy bus cycle is never aborted when `bus_uses_ready` is 0: the phase waits for `bus_busy` to fall. With `bus_uses_ready` set, `bus_abort` is 1 only once `bus_ws_done` is 1 with `bus_ready_n` high. With `bus_ready_n` low the cycle is allowed to finish.
- R9: `wdog_ovf` has no effect while `boot_mode` is 1.
- R10: A `bidir_set` pulse in normal operation sets `bidir_en`. With it set, `rst_pin_pull` is 1 for all 512 sequence cycles of a software or watchdog reset, and 0 for pin-caused resets.
- R11: `bidir_en` is 0 whenever the sequencer returns to normal operation.
- R12: Requests arriving together are resolved as pin first, then watchdog, then software.
- R13: For pin and software causes, `bus_abort` is 1 in the transition phase whenever `bus_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| ext_rst_n | input | 1 | External reset level, active low, raw |
| prog_volt_hi | input | 1 | Programming-voltage level; high marks a warm pin reset |
| boot_mode | input | 1 | Bootstrap-loader mode active; masks watchdog resets |
| soft_rst_req | input | 1 | Software reset request pulse |
| wdog_ovf | input | 1 | Watchdog overflow pulse |
| bidir_set | input | 1 | Software write setting the bidirectional-enable bit |
| int_busy | input | 1 | An internal access is still in progress |
| bus_busy | input | 1 | An external bus cycle is outstanding |
| bus_uses_ready | input | 1 | The outstanding cycle is terminated by READY |
| bus_ws_done | input | 1 | Programmed wait states of the cycle have elapsed |
| bus_ready_n | input | 1 | READY level, active low |
| core_rst | output | 1 | Internal reset to the core, active high |
| io_hiz | output | 1 | Forces all I/O pads to high impedance |
| rst_out_n | output | 1 | Reset indication output, active low |
| rst_pin_pull | output | 1 | Open-drain pull-down enable for the reset pin |
| hold_cancel | output | 1 | Cancel pending hold requests (transition phase) |
| bus_abort | output | 1 | Abort the outstanding external bus cycle |
| rst_cause | output | 2 | Cause of the last reset |
| bidir_en | output | 1 | Bidirectional reset enable bit |

## Verification
The embedded assertions watch, on every clock, the sequence-length bookkeeping, the hold of the stretch state while the pin stays low, the watchdog mask in boot mode, the clearing of the bidirectional bit on return to normal operation, the cause-dependent bus abort rules, and watchdog-over-software priority. Behaviour that spans whole scenarios can only be shown by the bench, using its cycle-accurate reference model. This covers the clock-free entry on the pin, the exact 515- and 512-cycle reset durations, the three-edge release delay, the kept cause after a stretched sequence, and the 512-cycle pull on the pin.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_TRANS = 3'd1,
        ST_SEQ   = 3'd2,
        ST_EXT   = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_COLD = 2'd0,
        CAUSE_WARM = 2'd1,
        CAUSE_WDOG = 2'd2,
        CAUSE_SOFT = 2'd3
    } rst_cause_e;

    typedef struct packed {
        seq_state_e state;
        rst_cause_e cause;
        logic       bidir_en;
    } seq_ctl_t;

endpackage

// File: rtl/rstseq_pin_sync.sv
module rstseq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_sync
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_d[i] = 1'b1;
        end else begin : g_next
            assign stage_d[i] = stage_q[i-1];
        end
    end

    // the low level clears the chain at once; only the release is clocked
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/rstseq_seq_timer.sv
module rstseq_seq_timer #(
    parameter int CYCLES = 512
) (
    input  logic                        clk,
    input  logic                        run,
    output logic                        last,
    output logic [$clog2(CYCLES)-1:0]   count
);
    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LAST_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign last  = run && (cnt_q == LAST_VAL);
    assign count = cnt_q;

endmodule

// File: rtl/rstseq_bus_gate.sv
module rstseq_bus_gate
    import rstseq_pkg::*;
(
    input  logic       in_trans,
    input  rst_cause_e cause,
    input  logic       int_busy,
    input  logic       bus_busy,
    input  logic       bus_uses_ready,
    input  logic       bus_ws_done,
    input  logic       bus_ready_n,
    output logic       bus_abort,
    output logic       trans_done
);
    logic abort_ok;

    always_comb begin
        // watchdog lets a cycle finish unless READY stays high after the wait states
        if (cause == CAUSE_WDOG) begin
            abort_ok = bus_uses_ready && bus_ws_done && bus_ready_n;
        end else begin
            abort_ok = 1'b1;
        end
        bus_abort  = in_trans && bus_busy && abort_ok;
        trans_done = in_trans && !int_busy && (!bus_busy || bus_abort);
    end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SEQ_CYCLES  = 512
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       prog_volt_hi,
    input  logic       boot_mode,
    input  logic       soft_rst_req,
    input  logic       wdog_ovf,
    input  logic       bidir_set,
    input  logic       int_busy,
    input  logic       bus_busy,
    input  logic       bus_uses_ready,
    input  logic       bus_ws_done,
    input  logic       bus_ready_n,
    output logic       core_rst,
    output logic       io_hiz,
    output logic       rst_out_n,
    output logic       rst_pin_pull,
    output logic       hold_cancel,
    output logic       bus_abort,
    output logic [1:0] rst_cause,
    output logic       bidir_en
);
    localparam int CW = $clog2(SEQ_CYCLES);

    seq_ctl_t      ctl_d;
    seq_ctl_t      ctl_q;
    logic          pin_sync;
    logic          seq_last;
    logic [CW-1:0] seq_cnt;
    logic          in_trans;
    logic          trans_done;
    logic          pin_cause;
    rst_cause_e    pin_kind;

    rstseq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .pin_n    (ext_rst_n),
        .pin_sync (pin_sync)
    );

    rstseq_seq_timer #(.CYCLES(SEQ_CYCLES)) u_timer (
        .clk   (clk),
        .run   (ctl_q.state == ST_SEQ),
        .last  (seq_last),
        .count (seq_cnt)
    );

    assign in_trans = (ctl_q.state == ST_TRANS);

    rstseq_bus_gate u_gate (
        .in_trans       (in_trans),
        .cause          (ctl_q.cause),
        .int_busy       (int_busy),
        .bus_busy       (bus_busy),
        .bus_uses_ready (bus_uses_ready),
        .bus_ws_done    (bus_ws_done),
        .bus_ready_n    (bus_ready_n),
        .bus_abort      (bus_abort),
        .trans_done     (trans_done)
    );

    assign pin_kind = prog_volt_hi ? CAUSE_WARM : CAUSE_COLD;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            ST_RUN: begin
                if (!pin_sync) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.cause = pin_kind;
                end else if (wdog_ovf && !boot_mode) begin
                    ctl_d.state = ST_TRANS;
                    ctl_d.cause = CAUSE_WDOG;
                end else if (soft_rst_req) begin
                    ctl_d.state = ST_TRANS;
                    ctl_d.cause = CAUSE_SOFT;
                end else if (bidir_set) begin
                    ctl_d.bidir_en = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!pin_sync) begin
                    ctl_d.cause = pin_kind;
                end else begin
                    ctl_d.state = ST_TRANS;
                end
            end
            ST_TRANS: begin
                if (!pin_sync) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.cause = pin_kind;
                end else if (trans_done) begin
                    ctl_d.state = ST_SEQ;
                end
            end
            ST_SEQ: begin
                if (seq_last) begin
                    if (pin_sync) begin
                        ctl_d.state    = ST_RUN;
                        ctl_d.bidir_en = 1'b0;
                    end else begin
                        ctl_d.state = ST_EXT;
                    end
                end
            end
            ST_EXT: begin
                if (pin_sync) begin
                    ctl_d.state    = ST_RUN;
                    ctl_d.bidir_en = 1'b0;
                end
            end
            default: begin
                ctl_d.state = ST_HOLD;
                ctl_d.cause = pin_kind;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign pin_cause    = (ctl_q.cause == CAUSE_COLD) || (ctl_q.cause == CAUSE_WARM);
    assign core_rst     = !ext_rst_n
                        || (ctl_q.state == ST_HOLD)
                        || (ctl_q.state == ST_SEQ)
                        || (ctl_q.state == ST_EXT)
                        || (in_trans && pin_cause);
    assign io_hiz       = core_rst;
    assign rst_out_n    = ext_rst_n && (ctl_q.state == ST_RUN);
    assign rst_pin_pull = (ctl_q.state == ST_SEQ) && ctl_q.bidir_en && !pin_cause;
    assign hold_cancel  = in_trans;
    assign rst_cause    = ctl_q.cause;
    assign bidir_en     = ctl_q.bidir_en;

    // R5
    seq_start_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(ctl_q.state == ST_SEQ) |-> (seq_cnt == '0));

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_q.state == ST_SEQ && !seq_last) |=> (ctl_q.state == ST_SEQ));

    // R5
    seq_end_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_q.state == ST_SEQ && seq_last) |=> (ctl_q.state != ST_SEQ));

    // R4
    trans_wait_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (in_trans && int_busy) |=> (ctl_q.state != ST_SEQ));

    // R6
    ext_stay_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_q.state == ST_EXT && !pin_sync) |=> (ctl_q.state == ST_EXT));

    // R9
    boot_mask_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_q.state == ST_RUN && pin_sync && wdog_ovf && boot_mode && !soft_rst_req)
        |=> (ctl_q.state == ST_RUN));

    // R11
    bidir_clear_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_q.state == ST_RUN && $past(ctl_q.state) != ST_RUN) |-> !bidir_en);

    // R8
    wdog_finish_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (hold_cancel && rst_cause == CAUSE_WDOG && !bus_uses_ready) |-> !bus_abort);

    // R13
    soft_abort_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (hold_cancel && rst_cause == CAUSE_SOFT && bus_busy) |-> bus_abort);

    // R12
    wdog_prio_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (ctl_q.state == ST_RUN && pin_sync && wdog_ovf && !boot_mode)
        |=> (rst_cause == CAUSE_WDOG));

    // R10
    pull_span_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (rst_pin_pull && !seq_last) |=> rst_pin_pull);

endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
    localparam int SYNC   = 2;
    localparam int SEQLEN = 512;
    localparam int M_HOLD = 0, M_TRANS = 1, M_SEQ = 2, M_EXT = 3, M_RUN = 4;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0;
    logic prog_volt_hi = 1'b0;
    logic boot_mode = 1'b0;
    logic soft_rst_req = 1'b0;
    logic wdog_ovf = 1'b0;
    logic bidir_set = 1'b0;
    logic int_busy = 1'b0;
    logic bus_busy = 1'b0;
    logic bus_uses_ready = 1'b0;
    logic bus_ws_done = 1'b0;
    logic bus_ready_n = 1'b0;
    logic core_rst, io_hiz, rst_out_n, rst_pin_pull, hold_cancel, bus_abort, bidir_en;
    logic [1:0] rst_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    rstseq_top uut (
        .clk(clk), .ext_rst_n(ext_rst_n), .prog_volt_hi(prog_volt_hi),
        .boot_mode(boot_mode), .soft_rst_req(soft_rst_req), .wdog_ovf(wdog_ovf),
        .bidir_set(bidir_set), .int_busy(int_busy), .bus_busy(bus_busy),
        .bus_uses_ready(bus_uses_ready), .bus_ws_done(bus_ws_done),
        .bus_ready_n(bus_ready_n), .core_rst(core_rst), .io_hiz(io_hiz),
        .rst_out_n(rst_out_n), .rst_pin_pull(rst_pin_pull),
        .hold_cancel(hold_cancel), .bus_abort(bus_abort),
        .rst_cause(rst_cause), .bidir_en(bidir_en)
    );

    // behavioural reference model
    int m_st = M_HOLD;
    int m_cnt = 0;
    int m_hi = 0;
    int m_cause = 0;
    bit m_bdr = 1'b0;
    bit m_ps;

    function automatic bit m_abort();
        if (m_st != M_TRANS || !bus_busy) return 1'b0;
        if (m_cause == 2) return bus_uses_ready && bus_ws_done && bus_ready_n;
        return 1'b1;
    endfunction

    function automatic bit m_core();
        return !ext_rst_n || m_st == M_HOLD || m_st == M_SEQ || m_st == M_EXT
               || (m_st == M_TRANS && m_cause < 2);
    endfunction

    always @(negedge ext_rst_n) m_hi = 0;

    always @(posedge clk) begin
        m_ps = ext_rst_n && (m_hi >= SYNC);
        if (!ext_rst_n) m_hi = 0;
        else if (m_hi < SYNC) m_hi = m_hi + 1;
        case (m_st)
            M_RUN: begin
                if (!m_ps) begin m_st = M_HOLD; m_cause = prog_volt_hi ? 1 : 0; end
                else if (wdog_ovf && !boot_mode) begin m_st = M_TRANS; m_cause = 2; end
                else if (soft_rst_req) begin m_st = M_TRANS; m_cause = 3; end
                else if (bidir_set) m_bdr = 1'b1;
            end
            M_HOLD: begin
                if (!m_ps) m_cause = prog_volt_hi ? 1 : 0;
                else m_st = M_TRANS;
            end
            M_TRANS: begin
                if (!m_ps) begin m_st = M_HOLD; m_cause = prog_volt_hi ? 1 : 0; end
                else if (!int_busy && (!bus_busy || m_abort())) begin m_st = M_SEQ; m_cnt = 0; end
            end
            M_SEQ: begin
                if (m_cnt == SEQLEN - 1) begin
                    if (m_ps) begin m_st = M_RUN; m_bdr = 1'b0; end
                    else m_st = M_EXT;
                end else m_cnt = m_cnt + 1;
            end
            default: begin
                if (m_ps) begin m_st = M_RUN; m_bdr = 1'b0; end
            end
        endcase
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5", "core_rst", core_rst, m_core());
            chk("R1", "io_hiz", io_hiz, m_core());
            chk("R2", "rst_out_n", rst_out_n, ext_rst_n && m_st == M_RUN);
            chk("R10", "rst_pin_pull", rst_pin_pull, m_st == M_SEQ && m_bdr && m_cause >= 2);
            chk("R4", "hold_cancel", hold_cancel, m_st == M_TRANS);
            chk("R8", "bus_abort", bus_abort, m_abort());
            chk("R3", "rst_cause", rst_cause, m_cause);
            chk("R11", "bidir_en", bidir_en, m_bdr);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_run(output int n_core, output int n_pull);
        n_core = 0;
        n_pull = 0;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (rst_out_n) break;
            if (core_rst) n_core++;
            if (rst_pin_pull) n_pull++;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int nc, np, ns;
        // R1: cold entry before any clock edge
        #1;
        chk("R1", "core_rst at t0", core_rst, 1);
        chk("R1", "io_hiz at t0", io_hiz, 1);
        chk("R1", "rst_out_n at t0", rst_out_n, 0);
        repeat (2) step();
        cmp_en = 1'b1;
        repeat (4) step();
        ext_rst_n = 1'b1;
        wait_run(nc, np);
        chk("R2", "pin reset core_rst cycles", nc, SYNC + 1 + SEQLEN);
        chk("R3", "cold cause", rst_cause, 0);

        // R7 / R4: software reset with a draining internal access
        soft_rst_req = 1'b1; int_busy = 1'b1;
        step();
        soft_rst_req = 1'b0;
        chk("R4", "hold_cancel in transition", hold_cancel, 1);
        chk("R4", "core_rst low in soft transition", core_rst, 0);
        step();
        chk("R4", "transition held by int_busy", hold_cancel, 1);
        int_busy = 1'b0;
        wait_run(nc, np);
        chk("R5", "soft sequence length", nc, SEQLEN);
        chk("R7", "soft cause", rst_cause, 3);

        // R9: watchdog masked in boot mode
        boot_mode = 1'b1; wdog_ovf = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9", "no reset in boot mode", rst_out_n, 1);
        end
        wdog_ovf = 1'b0; boot_mode = 1'b0;

        // R8: watchdog with plain bus cycle lets it finish
        bus_busy = 1'b1; bus_uses_ready = 1'b0;
        wdog_ovf = 1'b1;
        step();
        wdog_ovf = 1'b0;
        chk("R8", "no abort of plain cycle", bus_abort, 0);
        step(); step();
        chk("R8", "still waiting for bus", hold_cancel, 1);
        bus_busy = 1'b0;
        wait_run(nc, np);
        chk("R5", "wdog sequence length", nc, SEQLEN);
        chk("R3", "wdog cause", rst_cause, 2);

        // R8: READY-terminated cycle
        bus_busy = 1'b1; bus_uses_ready = 1'b1; bus_ws_done = 1'b0; bus_ready_n = 1'b1;
        wdog_ovf = 1'b1;
        step();
        wdog_ovf = 1'b0;
        chk("R8", "no abort before wait states", bus_abort, 0);
        bus_ws_done = 1'b1; bus_ready_n = 1'b0;
        #1;
        chk("R8", "no abort when READY low", bus_abort, 0);
        step();
        chk("R8", "finishing cycle keeps transition", hold_cancel, 1);
        bus_ready_n = 1'b1;
        #1;
        chk("R8", "abort when READY high", bus_abort, 1);
        wait_run(nc, np);
        chk("R5", "sequence after abort", nc, SEQLEN);
        bus_busy = 1'b0; bus_uses_ready = 1'b0; bus_ws_done = 1'b0; bus_ready_n = 1'b0;

        // R10 / R11: bidirectional software reset
        bidir_set = 1'b1;
        step();
        bidir_set = 1'b0;
        chk("R10", "bidir_en set", bidir_en, 1);
        soft_rst_req = 1'b1;
        step();
        soft_rst_req = 1'b0;
        wait_run(nc, np);
        chk("R10", "pin pull cycles", np, SEQLEN);
        chk("R11", "bidir_en cleared", bidir_en, 0);

        // R10 / R3 / R11: warm pin reset with bit set
        bidir_set = 1'b1;
        step();
        bidir_set = 1'b0;
        prog_volt_hi = 1'b1;
        ext_rst_n = 1'b0;
        #1;
        chk("R1", "async core_rst from run", core_rst, 1);
        chk("R1", "async io_hiz from run", io_hiz, 1);
        repeat (3) step();
        ext_rst_n = 1'b1;
        wait_run(nc, np);
        chk("R10", "no pull on pin reset", np, 0);
        chk("R3", "warm cause", rst_cause, 1);
        chk("R11", "bidir_en cleared after pin reset", bidir_en, 0);

        // R6: pin low through the end of a software sequence
        soft_rst_req = 1'b1;
        step();
        soft_rst_req = 1'b0;
        repeat (100) step();
        ext_rst_n = 1'b0;
        repeat (600) step();
        chk("R6", "core_rst stretched", core_rst, 1);
        chk("R6", "rst_out_n low while stretched", rst_out_n, 0);
        ext_rst_n = 1'b1;
        ns = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            ns++;
            if (rst_out_n) break;
        end
        chk("R6", "release delay edges", ns, SYNC + 1);
        chk("R6", "cause kept", rst_cause, 3);

        // R12: pin beats watchdog, watchdog beats software
        prog_volt_hi = 1'b0;
        ext_rst_n = 1'b0; wdog_ovf = 1'b1;
        step();
        wdog_ovf = 1'b0;
        step();
        ext_rst_n = 1'b1;
        wait_run(nc, np);
        chk("R12", "pin over watchdog", rst_cause, 0);
        wdog_ovf = 1'b1; soft_rst_req = 1'b1;
        step();
        wdog_ovf = 1'b0; soft_rst_req = 1'b0;
        chk("R12", "watchdog over software", rst_cause, 2);
        wait_run(nc, np);

        // R13: software reset aborts a busy bus cycle
        bus_busy = 1'b1;
        soft_rst_req = 1'b1;
        step();
        soft_rst_req = 1'b0;
        chk("R13", "soft abort", bus_abort, 1);
        wait_run(nc, np);
        chk("R13", "sequence after soft abort", nc, SEQLEN);
        bus_busy = 1'b0;
        repeat (3) step();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule